// File: doc/BRIEF.md
# Write Command Clock-Count Guard

This block protects a serial non-volatile memory against writes that come from a miscounted command frame. Within each frame, meaning the period while the select input is high, it counts the serial-clock rising edges from the start bit onward. A protocol decoder elsewhere tells it when the start bit has been seen and which command class it has decoded. When select drops, that is the moment an internal write would begin. The guard then compares the count with the exact length fixed for that command. It emits either a one-cycle commit pulse or a one-cycle cancel pulse.

Any frame that received even one extra or one missing clock is refused. One example is a write-disable frame hit by a single noise pulse. The decoder then sees it as an erase of address zero, and the guard cancels it. Read frames and frames with no start bit produce no pulse at all. The frame lengths follow from the address width parameter and the data width parameter.

Top module: `wr_clk_guard`

## Requirements
- R1: While reset is high, and in the first cycle after it is released with select low, both commit and cancel are low.
- R2: A strobe on sclk_rise is counted only when select and start_seen are both high in that cycle. Strobes with start_seen low (dummy clocks before the start bit) do not change the verdict.
- R3: Command classes 2 (data write) and 3 (write all) commit only when the count at select fall equals ADDR_W+DATA_W+3, which is 25 with the defaults.
- R4: Command classes 4 (erase), 5 (erase all), 6 (write enable) and 7 (write disable) commit only when the count equals ADDR_W+3, which is 9 with the defaults.
- R5: The cycle in which select is first seen low after being high is the fall cycle. The verdict pulse appears in the cycle after the fall cycle and lasts exactly one cycle.
- R6: A guarded class whose count is above or below its required length produces a cancel pulse and no commit.
- R7: Command class 1 (read) and class 0 (nothing decoded) produce neither pulse at select fall.
- R8: The counter saturates at its all-ones value instead of wrapping. With the defaults the counter is 5 bits wide, so a frame of 57 counted clocks is cancelled and does not alias to 25.
- R9: The count clears while select is low. Strobes between frames, and a strobe that arrives in the fall cycle itself, are not counted.
- R10: Commit and cancel are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select; high marks a frame |
| sclk_rise | input | 1 | One-cycle strobe per serial-clock rising edge |
| start_seen | input | 1 | High from the start-bit strobe until the frame ends |
| cmd_class | input | 3 | Decoded class: 0 none, 1 read, 2 write, 3 write all, 4 erase, 5 erase all, 6 enable, 7 disable |
| commit | output | 1 | One-cycle pulse: command may execute |
| cancel | output | 1 | One-cycle pulse: command refused |

## Verification
Two functions can land in the same cycle: the counting of a serial-clock strobe, and the clearing and judging that happen when select falls. The bench provokes this by driving a strobe in the very cycle select drops, after exactly the required number of counted clocks. A commit then shows that the late strobe was cleared rather than added. A cancel would reveal that the count path won over the frame-end path. Random frames with lengths clustered around each required value also push the final strobe right up against the select fall.

// File: rtl/wcg_pkg.sv
package wcg_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_WRALL = 3'd3,
        CMD_ERASE = 3'd4,
        CMD_ERALL = 3'd5,
        CMD_WEN   = 3'd6,
        CMD_WDS   = 3'd7
    } cmd_class_e;

    typedef struct packed {
        logic commit;
        logic cancel;
    } verdict_t;

    // Frames of these classes must be length-checked at select fall.
    function automatic logic is_guarded(cmd_class_e c);
        return (c != CMD_NONE) && (c != CMD_READ);
    endfunction

    // Classes whose frame carries a data word after the address.
    function automatic logic carries_data(cmd_class_e c);
        return (c == CMD_WRITE) || (c == CMD_WRALL);
    endfunction

    // Start bit + two opcode bits + address (+ data word).
    function automatic int unsigned frame_len(int unsigned aw, int unsigned dw, logic with_data);
        return with_data ? (aw + dw + 3) : (aw + 3);
    endfunction

endpackage

// File: rtl/wcg_edge_tally.sv
module wcg_edge_tally #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             sclk_rise,
    input  logic             start_seen,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            cnt <= '0;
        end else if (sclk_rise && start_seen && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wcg_frame_end.sv
module wcg_frame_end (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    output logic frame_end
);
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= sel;
        end
    end

    assign frame_end = sel_q && !sel;
endmodule

// File: rtl/wcg_len_judge.sv
module wcg_len_judge
    import wcg_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int LONG_LEN  = 25,
    parameter int SHORT_LEN = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_end,
    input  cmd_class_e       cls,
    input  logic [CNT_W-1:0] cnt,
    output verdict_t         verdict
);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_LEN);
    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_LEN);

    verdict_t         verdict_d;
    logic [CNT_W-1:0] target;

    always_comb begin
        verdict_d = '0;
        target    = carries_data(cls) ? LONG_C : SHORT_C;
        if (frame_end && is_guarded(cls)) begin
            if (cnt == target) begin
                verdict_d.commit = 1'b1;
            end else begin
                verdict_d.cancel = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= '0;
        end else begin
            verdict <= verdict_d;
        end
    end
endmodule

// File: rtl/wr_clk_guard.sv
module wr_clk_guard
    import wcg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       sclk_rise,
    input  logic       start_seen,
    input  logic [2:0] cmd_class,
    output logic       commit,
    output logic       cancel
);
    localparam int LONG_LEN  = int'(frame_len(ADDR_W, DATA_W, 1'b1));
    localparam int SHORT_LEN = int'(frame_len(ADDR_W, DATA_W, 1'b0));
    // Headroom above the longest frame so saturation never equals it.
    localparam int CNT_W     = $clog2(LONG_LEN + 2);

    logic [CNT_W-1:0] cnt_q;
    logic             frame_end;
    verdict_t         verdict;

    wcg_edge_tally #(.CNT_W(CNT_W)) tally_i (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel),
        .sclk_rise  (sclk_rise),
        .start_seen (start_seen),
        .cnt        (cnt_q)
    );

    wcg_frame_end fend_i (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .frame_end (frame_end)
    );

    wcg_len_judge #(
        .CNT_W     (CNT_W),
        .LONG_LEN  (LONG_LEN),
        .SHORT_LEN (SHORT_LEN)
    ) judge_i (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .cls       (cmd_class_e'(cmd_class)),
        .cnt       (cnt_q),
        .verdict   (verdict)
    );

    assign commit = verdict.commit;
    assign cancel = verdict.cancel;
endmodule

// File: rtl/wcg_guard_chk.sv
module wcg_guard_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             sel,
    input logic [2:0]       cmd_class,
    input logic             commit,
    input logic             cancel,
    input logic [CNT_W-1:0] cnt
);
    // R10
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(commit && cancel));

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        (commit || cancel) |=> !(commit || cancel));

    // R5
    pulse_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (commit || cancel) |-> ($past(sel, 2) && !$past(sel)));

    // R5
    verdict_given_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sel) && !sel && (cmd_class >= 3'd2)) |=> (commit || cancel));

    // R7
    read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sel) && !sel && (cmd_class <= 3'd1)) |=> !(commit || cancel));

    // R9
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (cnt == '0));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && $past(sel)) |-> (cnt >= $past(cnt)));
endmodule

bind wr_clk_guard wcg_guard_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .cmd_class (cmd_class),
    .commit    (commit),
    .cancel    (cancel),
    .cnt       (cnt_q)
);

// File: tb/wr_clk_guard_tb_top.sv
module wr_clk_guard_tb_top;
    localparam int AW = 6;
    localparam int DW = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic       sclk_rise = 1'b0;
    logic       start_seen = 1'b0;
    logic [2:0] cmd_class = 3'd0;
    logic       commit;
    logic       cancel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wr_clk_guard #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel),
        .sclk_rise  (sclk_rise),
        .start_seen (start_seen),
        .cmd_class  (cmd_class),
        .commit     (commit),
        .cancel     (cancel)
    );

    // 0 = no pulse, 1 = commit, 2 = cancel
    function automatic int exp_verdict(int cls, int n);
        int need;
        if (cls < 2) return 0;
        need = (cls == 2 || cls == 3) ? (AW + DW + 3) : (AW + 3);
        return (n == need) ? 1 : 2;
    endfunction

    function automatic string req_of(int cls, int n);
        int v;
        v = exp_verdict(cls, n);
        if (v == 0) return "R7";
        if (v == 2) return "R6";
        return (cls < 4) ? "R3" : "R4";
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic int observed();
        return {30'd0, cancel, commit};
    endfunction

    task automatic strobes(int n, bit ss);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sclk_rise  = 1'b1;
            start_seen = ss;
            @(negedge clk);
            sclk_rise  = 1'b0;
        end
    endtask

    task automatic run_frame(int cls, int dummies, int n, bit strobe_at_fall, string req);
        int exp;
        exp = exp_verdict(cls, n);
        @(negedge clk);
        sel = 1'b1;
        cmd_class = 3'(cls);
        start_seen = 1'b0;
        strobes(dummies, 1'b0);
        strobes(n, 1'b1);
        @(negedge clk);
        sel = 1'b0;
        sclk_rise = strobe_at_fall;
        @(negedge clk);
        sclk_rise = 1'b0;
        start_seen = 1'b0;
        check(req, observed(), exp);
        @(negedge clk);
        // R5: pulse lasts one cycle
        check("R5", observed(), 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cls, n, r;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", observed(), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", observed(), 0);

        run_frame(2, 0, 25, 1'b0, "R3");
        run_frame(3, 0, 25, 1'b0, "R3");
        run_frame(4, 0, 9, 1'b0, "R4");
        run_frame(5, 0, 9, 1'b0, "R4");
        run_frame(6, 0, 9, 1'b0, "R4");
        run_frame(7, 0, 9, 1'b0, "R4");
        run_frame(2, 0, 24, 1'b0, "R6");
        run_frame(2, 0, 26, 1'b0, "R6");
        run_frame(4, 0, 10, 1'b0, "R6");   // noise-lengthened disable seen as erase
        run_frame(6, 0, 8, 1'b0, "R6");
        run_frame(1, 0, 25, 1'b0, "R7");
        run_frame(0, 0, 0, 1'b0, "R7");
        run_frame(2, 5, 25, 1'b0, "R2");
        run_frame(7, 3, 9, 1'b0, "R2");
        // R9: strobes while select is low
        @(negedge clk);
        start_seen = 1'b1;
        strobes(4, 1'b1);
        run_frame(4, 0, 9, 1'b0, "R9");
        // R9: strobe in the fall cycle is not counted
        run_frame(4, 0, 9, 1'b1, "R9");
        run_frame(2, 0, 25, 1'b1, "R9");
        // R8: saturation instead of wrap
        run_frame(2, 0, 57, 1'b0, "R8");
        run_frame(2, 0, 40, 1'b0, "R8");

        r = $urandom(32'h5eed);
        for (int k = 0; k < 40; k++) begin
            cls = int'($urandom_range(7, 0));
            if ($urandom_range(1, 0) == 1) begin
                n = ((cls == 2 || cls == 3) ? 25 : 9) + int'($urandom_range(2, 0)) - 1;
            end else begin
                n = int'($urandom_range(40, 1));
            end
            run_frame(cls, int'($urandom_range(3, 0)), n, 1'($urandom_range(1, 0)),
                      req_of(cls, n));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule